// File: doc/BRIEF.md
# Hub-execution branch and line-fetch controller

This block steers a processing core that can run code either from its own local register memory or from a large shared memory. It keeps a byte pointer into shared memory and a mode (local or hub). When a hub jump is executed, it loads a line of eight consecutive words starting at the target into a small window, and then hands out the window's words one per cycle as instructions. Running off the end of the window loads the next line. An ordinary local branch drops the core back into local mode and leaves the pointer at the word after that branch.

The core shows each instruction it runs from local memory on `loc_instr`, together with its carry and zero flags. While in hub mode, the core runs the words this block issues and holds its local fetch. Shared memory is read through a request/grant port. One word is returned in each granted cycle, and the address is held until the grant arrives.

Top module: `hubx_branch_ctrl`

## Requirements
- R1: After reset the block is in local mode (`hub_mode`=0), `hub_ptr` is 0, and both `issue_valid` and `mem_req` are low.
- R2: Instruction fields: opcode [31:25], Z [24], C [23], immediate flag I [22] (1 = immediate), condition [21:18], D [17:9], S [8:0]; a hub jump has opcode 0x68. With I=1 and C=Z, the target byte address is {D,S} followed by two zero bits (20 bits).
- R3: With I=0 the target is the `reg_d` value with its two low bits cleared, and C and Z have no effect.
- R4: With I=1 and C=1, Z=0, the target is `hub_ptr` plus the scaled immediate; with Z=1, C=0 it is `hub_ptr` minus it, modulo 2^20. `hub_ptr` is the address of the jump itself when in hub mode, or the held pointer when in local mode.
- R5: A taken hub jump in local mode enters hub mode. A taken hub jump issued in hub mode reloads the window at the new target and stays in hub mode.
- R6: A line load makes eight reads at target, target+4, ..., target+28. Each read holds `mem_req` and `mem_addr` until it is granted. Nothing is issued during the load, and the word at the target is issued in the cycle after the eighth grant, with `hub_ptr` equal to the target.
- R7: An instruction executes only if bit {C flag, Z flag} (C as the high index bit) of its condition field is 1. A hub jump or local branch that fails its condition has no effect.
- R8: A taken local branch (opcodes 0x5C to 0x5F) issued in hub mode returns to local mode, with `hub_ptr` set to its own address plus 4. A local branch arriving in local mode has no effect on the block.
- R9: A window word whose top byte is 0xFE is not issued; it takes one cycle and the pointer moves past it.
- R10: After the eighth word of a window, the next line is loaded automatically from line start plus 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_valid | input | 1 | An instruction from local memory is executing |
| loc_instr | input | 32 | That instruction word |
| reg_d | input | 32 | Value of the D operand register |
| c_flag | input | 1 | Core carry flag |
| z_flag | input | 1 | Core zero flag |
| mem_req | output | 1 | Shared-memory read request |
| mem_addr | output | 20 | Shared-memory byte address |
| mem_gnt | input | 1 | Grant; read data valid this cycle |
| mem_rdata | input | 32 | Shared-memory read data |
| hub_mode | output | 1 | Block is in hub mode (loading or issuing) |
| hub_ptr | output | 20 | Hub program pointer |
| issue_valid | output | 1 | A window word is issued this cycle |
| issue_instr | output | 32 | The issued word |

## Verification
The hardest path to reach from the ports is a single run of hub code that, with no local step in between, skips an inline no-op word, passes over a failed local branch, crosses the end of the window into an automatic reload, and then chains into a second hub jump. The bench gets there by writing that code into its shared-memory model before a single local-mode jump. It then follows the stream one cycle at a time. Grants are given only every other cycle, so each load shows held requests, and the first issue can be checked to fall exactly one cycle after the eighth grant.

// File: rtl/hubx_pkg.sv
package hubx_pkg;

   typedef enum logic [1:0] {
      ST_LOCAL = 2'd0,
      ST_FETCH = 2'd1,
      ST_RUN   = 2'd2
   } hx_state_e;

   localparam logic [6:0] OP_HJMP     = 7'h68;
   localparam logic [4:0] OP_LBR_HIGH = 5'h17;   // 0x5C..0x5F
   localparam logic [7:0] NOP_TOPBYTE = 8'hFE;

   typedef struct packed {
      logic hjmp;
      logic lbr;
      logic nop;
   } hx_dec_t;

endpackage

// File: rtl/hubx_decode.sv
module hubx_decode
   import hubx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int FIELD_W = 9,
   parameter int ADDR_W  = 20,
   parameter bit REL_EN  = 1'b1
) (
   input  logic [DATA_W-1:0] instr,
   input  logic              c_flag,
   input  logic              z_flag,
   input  logic [ADDR_W-1:0] cur_ptr,
   input  logic [DATA_W-1:0] reg_d,
   output hx_dec_t           dec,
   output logic              taken,
   output logic [ADDR_W-1:0] target
);
   localparam int COND_LO = 2 * FIELD_W;
   localparam int IMM_BIT = COND_LO + 4;
   localparam int C_BIT   = IMM_BIT + 1;
   localparam int Z_BIT   = IMM_BIT + 2;
   localparam int OP_LO   = IMM_BIT + 3;

   logic [6:0]        opc;
   logic [3:0]        cond;
   logic              bit_c, bit_z, is_imm;
   logic [ADDR_W-1:0] imm_byte, rel_target, reg_target;

   assign opc    = instr[DATA_W-1:OP_LO];
   assign cond   = instr[COND_LO+3:COND_LO];
   assign is_imm = instr[IMM_BIT];
   assign bit_c  = instr[C_BIT];
   assign bit_z  = instr[Z_BIT];

   assign dec.hjmp = (opc == OP_HJMP);
   assign dec.lbr  = (opc[6:2] == OP_LBR_HIGH);
   assign dec.nop  = (instr[DATA_W-1 -: 8] == NOP_TOPBYTE);

   assign taken = cond[{c_flag, z_flag}];

   assign imm_byte   = ADDR_W'({instr[COND_LO-1:0], 2'b00});
   assign reg_target = reg_d[ADDR_W-1:0] & ~ADDR_W'(3);

   generate
      if (REL_EN) begin : g_rel
         always_comb begin
            if (bit_c && !bit_z)      rel_target = cur_ptr + imm_byte;
            else if (bit_z && !bit_c) rel_target = cur_ptr - imm_byte;
            else                      rel_target = imm_byte;
         end
      end else begin : g_abs
         assign rel_target = imm_byte;
      end
   endgenerate

   assign target = is_imm ? rel_target : reg_target;

endmodule

// File: rtl/hubx_window.sv
module hubx_window #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int IW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IW-1:0]     widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IW-1:0]     ridx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] slot_q [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (we && (widx == IW'(g))) slot_q[g] <= wdata;
         end
      end
   endgenerate

   assign rdata = slot_q[ridx];

endmodule

// File: rtl/hubx_branch_ctrl.sv
module hubx_branch_ctrl
   import hubx_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIELD_W    = 9,
   parameter int ADDR_W     = 20,
   parameter int LINE_WORDS = 8,
   parameter bit REL_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loc_valid,
   input  logic [DATA_W-1:0] loc_instr,
   input  logic [DATA_W-1:0] reg_d,
   input  logic              c_flag,
   input  logic              z_flag,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              hub_mode,
   output logic [ADDR_W-1:0] hub_ptr,
   output logic              issue_valid,
   output logic [DATA_W-1:0] issue_instr
);
   localparam int IDX_W      = $clog2(LINE_WORDS);
   localparam int LINE_BYTES = LINE_WORDS * 4;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LINE_WORDS - 1);

   generate
      if (ADDR_W != 2 * FIELD_W + 2) begin : g_bad_addr
         $error("ADDR_W must equal two operand fields plus two scale bits");
      end
      if (DATA_W != 2 * FIELD_W + 14) begin : g_bad_data
         $error("DATA_W does not match the instruction field layout");
      end
      if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
         $error("LINE_WORDS must be a power of two of at least 2");
      end
   endgenerate

   hx_state_e         st;
   logic [ADDR_W-1:0] line_base;
   logic [IDX_W-1:0]  idx, fcnt;
   logic              win_valid;

   logic [DATA_W-1:0] cur_word, dec_word;
   logic              dec_valid, taken, act;
   hx_dec_t           dec;
   logic [ADDR_W-1:0] target;

   assign hub_ptr  = line_base + ADDR_W'({idx, 2'b00});
   assign mem_addr = line_base + ADDR_W'({fcnt, 2'b00});
   assign mem_req  = (st == ST_FETCH);
   assign hub_mode = (st != ST_LOCAL);

   hubx_window #(
      .DATA_W (DATA_W),
      .DEPTH  (LINE_WORDS)
   ) u_win (
      .clk   (clk),
      .we    (mem_req && mem_gnt),
      .widx  (fcnt),
      .wdata (mem_rdata),
      .ridx  (idx),
      .rdata (cur_word)
   );

   always_comb begin
      dec_word  = loc_instr;
      dec_valid = 1'b0;
      if (st == ST_RUN) begin
         dec_word  = cur_word;
         dec_valid = win_valid;
      end else if (st == ST_LOCAL) begin
         dec_valid = loc_valid;
      end
   end

   hubx_decode #(
      .DATA_W  (DATA_W),
      .FIELD_W (FIELD_W),
      .ADDR_W  (ADDR_W),
      .REL_EN  (REL_EN)
   ) u_dec (
      .instr   (dec_word),
      .c_flag  (c_flag),
      .z_flag  (z_flag),
      .cur_ptr (hub_ptr),
      .reg_d   (reg_d),
      .dec     (dec),
      .taken   (taken),
      .target  (target)
   );

   assign act         = dec_valid && !dec.nop && taken;
   assign issue_valid = (st == ST_RUN) && win_valid && !dec.nop;
   assign issue_instr = cur_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_LOCAL;
         line_base <= '0;
         idx       <= '0;
         fcnt      <= '0;
         win_valid <= 1'b0;
      end else begin
         unique case (st)
            ST_LOCAL: begin
               if (act && dec.hjmp) begin
                  line_base <= target;
                  idx       <= '0;
                  fcnt      <= '0;
                  win_valid <= 1'b0;
                  st        <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_gnt) begin
                  fcnt <= fcnt + 1'b1;
                  if (fcnt == IDX_LAST) begin
                     win_valid <= 1'b1;
                     st        <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (act && dec.hjmp) begin
                  line_base <= target;
                  idx       <= '0;
                  fcnt      <= '0;
                  win_valid <= 1'b0;
                  st        <= ST_FETCH;
               end else if (act && dec.lbr) begin
                  line_base <= hub_ptr + ADDR_W'(4);
                  idx       <= '0;
                  st        <= ST_LOCAL;
               end else if (idx == IDX_LAST) begin
                  line_base <= line_base + ADDR_W'(LINE_BYTES);
                  idx       <= '0;
                  fcnt      <= '0;
                  win_valid <= 1'b0;
                  st        <= ST_FETCH;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: st <= ST_LOCAL;
         endcase
      end
   end

   // R6
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

   // R6
   no_issue_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !issue_valid);

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_gnt && (fcnt != IDX_LAST) |=> mem_addr == $past(mem_addr) + ADDR_W'(4));

   // R5
   enter_hub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOCAL) && act && dec.hjmp |=> mem_req && hub_mode && (hub_ptr == $past(target)));

   // R8
   exit_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN) && act && dec.lbr && !dec.hjmp |=> !hub_mode && (hub_ptr == $past(hub_ptr) + ADDR_W'(4)));

endmodule

// File: tb/sim_hubx_branch_ctrl.sv
module sim_hubx_branch_ctrl;

   localparam logic [6:0] HJ = 7'h68;
   localparam logic [6:0] LJ = 7'h5C;
   localparam logic [3:0] ALW = 4'hF;

   function automatic logic [31:0] enc(input logic [6:0] op, input logic z, input logic c,
                                       input logic i, input logic [3:0] cnd,
                                       input logic [8:0] d, input logic [8:0] s);
      return {op, z, c, i, cnd, d, s};
   endfunction

   function automatic logic [31:0] plain(input logic [19:0] a);
      return {7'h01, 7'h00, a[17:0]};
   endfunction

   localparam int NV = 6;
   localparam logic [31:0] V_INSTR [NV] = '{
      enc(HJ, 1'b0, 1'b0, 1'b1, ALW, 9'h000, 9'h010),   // R2 absolute
      enc(HJ, 1'b1, 1'b1, 1'b0, ALW, 9'h000, 9'h000),   // R3 register form
      enc(HJ, 1'b0, 1'b1, 1'b1, ALW, 9'h000, 9'h020),   // R4 forward
      enc(HJ, 1'b1, 1'b0, 1'b1, ALW, 9'h000, 9'h030),   // R4 backward
      enc(HJ, 1'b1, 1'b1, 1'b1, ALW, 9'h000, 9'h040),   // R2 both flags -> absolute
      enc(HJ, 1'b0, 1'b0, 1'b1, ALW, 9'h001, 9'h000)    // R2 D field high part
   };
   localparam logic [31:0] V_REGD [NV] = '{32'h0, 32'hFFF0_020B, 32'h0, 32'h0, 32'h0, 32'h0};
   localparam logic [19:0] V_TGT  [NV] = '{20'h040, 20'h208, 20'h28C, 20'h1D0, 20'h100, 20'h800};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        loc_valid = 1'b0;
   logic [31:0] loc_instr = '0;
   logic [31:0] reg_d = '0;
   logic        c_flag = 1'b0, z_flag = 1'b0;
   logic        mem_req, mem_gnt, hub_mode, issue_valid;
   logic [19:0] mem_addr, hub_ptr;
   logic [31:0] mem_rdata, issue_instr;
   logic        gnt_ph = 1'b0;
   logic [31:0] mem [1024];

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;
   always @(posedge clk) gnt_ph <= ~gnt_ph;
   assign mem_gnt   = mem_req & gnt_ph;
   assign mem_rdata = mem[mem_addr[11:2]];

   hubx_branch_ctrl u0 (
      .clk (clk), .rst_n (rst_n), .loc_valid (loc_valid), .loc_instr (loc_instr),
      .reg_d (reg_d), .c_flag (c_flag), .z_flag (z_flag), .mem_req (mem_req),
      .mem_addr (mem_addr), .mem_gnt (mem_gnt), .mem_rdata (mem_rdata),
      .hub_mode (hub_mode), .hub_ptr (hub_ptr), .issue_valid (issue_valid),
      .issue_instr (issue_instr)
   );

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         finish_run();
      end
   end

   // Starts at the negedge right after the jump was captured; ends at the
   // negedge where the first word must be issued (R6).
   task automatic watch_fetch(input logic [19:0] base, input string tag);
      int g = 0;
      int guard = 0;
      while (g < 8 && guard < 64) begin
         chk(mem_req, {tag, " R6 req"}, 32'(mem_req), 32'h1);
         chk(mem_addr == base + 20'(4 * g), {tag, " R6 addr"}, 32'(mem_addr), 32'(base + 20'(4 * g)));
         chk(!issue_valid, {tag, " R6 stall"}, 32'(issue_valid), 32'h0);
         if (mem_gnt) g++;
         guard++;
         @(negedge clk);
      end
      chk(issue_valid && hub_ptr == base, {tag, " R6 first issue ptr"}, 32'(hub_ptr), 32'(base));
      chk(issue_instr == mem[base[11:2]], {tag, " R6 first word"}, issue_instr, mem[base[11:2]]);
   endtask

   task automatic expect_issue(input logic [19:0] p, input string tag);
      chk(issue_valid && hub_ptr == p, {tag, " ptr"}, 32'(hub_ptr), 32'(p));
      chk(issue_instr == mem[p[11:2]], {tag, " word"}, issue_instr, mem[p[11:2]]);
      @(negedge clk);
   endtask

   task automatic local_jump(input logic [31:0] w, input logic [31:0] d);
      loc_instr = w;
      reg_d     = d;
      loc_valid = 1'b1;
      @(negedge clk);
      loc_valid = 1'b0;
   endtask

   initial begin
      for (int k = 0; k < 1024; k++) mem[k] = plain(20'(k * 4));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!hub_mode, "R1 mode", 32'(hub_mode), 32'h0);
      chk(hub_ptr == 20'h0, "R1 ptr", 32'(hub_ptr), 32'h0);
      chk(!issue_valid, "R1 issue", 32'(issue_valid), 32'h0);
      chk(!mem_req, "R1 req", 32'(mem_req), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: each jump lands on an always-taken local branch
      for (int v = 0; v < NV; v++) begin
         mem[V_TGT[v][11:2]] = enc(LJ, 1'b0, 1'b0, 1'b0, ALW, 9'h0, 9'h0);
         local_jump(V_INSTR[v], V_REGD[v]);
         watch_fetch(V_TGT[v], $sformatf("R2/R3/R4/R5 vec%0d", v));
         @(negedge clk);
         chk(!hub_mode, $sformatf("R8 vec%0d exit mode", v), 32'(hub_mode), 32'h0);
         chk(hub_ptr == V_TGT[v] + 20'h4, $sformatf("R8 vec%0d exit ptr", v),
             32'(hub_ptr), 32'(V_TGT[v] + 20'h4));
      end

      // R7: failed condition in local mode has no effect
      local_jump(enc(HJ, 1'b0, 1'b0, 1'b1, 4'h0, 9'h0, 9'h010), 32'h0);
      repeat (2) @(negedge clk);
      chk(!hub_mode && !mem_req, "R7 never-cond ignored", 32'(hub_mode), 32'h0);
      chk(hub_ptr == 20'h804, "R7 ptr kept", 32'(hub_ptr), 32'h804);

      // R7: condition bit selected by {C,Z}; cond=0010 runs only for C=0,Z=1
      c_flag = 1'b1; z_flag = 1'b0;
      local_jump(enc(HJ, 1'b0, 1'b0, 1'b1, 4'b0010, 9'h0, 9'h0C0), 32'h0);
      @(negedge clk);
      chk(!hub_mode, "R7 C=1,Z=0 not taken", 32'(hub_mode), 32'h0);
      c_flag = 1'b0; z_flag = 1'b1;
      mem[20'h300 >> 2] = enc(LJ, 1'b0, 1'b0, 1'b0, ALW, 9'h0, 9'h0);
      local_jump(enc(HJ, 1'b0, 1'b0, 1'b1, 4'b0010, 9'h0, 9'h0C0), 32'h0);
      watch_fetch(20'h300, "R7 C=0,Z=1 taken");
      @(negedge clk);
      chk(!hub_mode && hub_ptr == 20'h304, "R8 exit after cond jump", 32'(hub_ptr), 32'h304);
      c_flag = 1'b0; z_flag = 1'b0;

      // R8: local branch seen in local mode has no effect
      local_jump(enc(LJ, 1'b0, 1'b0, 1'b0, ALW, 9'h0, 9'h0), 32'h0);
      @(negedge clk);
      chk(!hub_mode && hub_ptr == 20'h304, "R8 local-mode branch ignored", 32'(hub_ptr), 32'h304);

      // R9/R10/R5: nop skip, failed branch, rollover, chained hub jump
      mem[20'h100 >> 2] = plain(20'h100);
      mem[20'h104 >> 2] = 32'hFE00_1234;
      mem[20'h108 >> 2] = enc(LJ, 1'b0, 1'b0, 1'b0, 4'h0, 9'h0, 9'h0);
      mem[20'h124 >> 2] = enc(HJ, 1'b0, 1'b0, 1'b1, ALW, 9'h0, 9'h100);
      mem[20'h400 >> 2] = enc(LJ, 1'b0, 1'b0, 1'b0, ALW, 9'h0, 9'h0);
      local_jump(enc(HJ, 1'b0, 1'b0, 1'b1, ALW, 9'h0, 9'h040), 32'h0);
      watch_fetch(20'h100, "R10 first line");
      @(negedge clk);
      chk(!issue_valid && hub_ptr == 20'h104, "R9 nop word not issued", 32'(issue_valid), 32'h0);
      @(negedge clk);
      expect_issue(20'h108, "R9 word after nop");
      chk(hub_mode, "R7 failed local branch stays in hub", 32'(hub_mode), 32'h1);
      for (int a = 'h10C; a <= 'h11C; a += 4) expect_issue(20'(a), "R10 straight line");
      watch_fetch(20'h120, "R10 next line");
      @(negedge clk);
      expect_issue(20'h124, "R5 chained jump issued");
      watch_fetch(20'h400, "R5 chained reload");
      @(negedge clk);
      chk(!hub_mode && hub_ptr == 20'h404, "R8 final exit", 32'(hub_ptr), 32'h404);

      finish_run();
   end

endmodule